// File: doc/BRIEF.md
# Sixty-four input interrupt concentrator with register bank

The block takes 64 interrupt lines, decides for each one whether it is pending, and combines the pending lines into two outputs: a normal interrupt line and a fast interrupt line. Each line can be set up on its own in several ways:
- it can be level-sensitive, or latched on an edge;
- the latching edge can be rising, falling or either;
- it can be enabled or masked;
- it can be raised by software;
- it can be routed to either output.

Software reaches all of this through a 32-bit register bank on a plain select/write-enable bus. Reads return data in the same cycle.

Every register is 64 bits wide and is split into two 32-bit words. The word for lines 0 to 31 sits at the register's base offset. The word for lines 32 to 63 sits 4 bytes above it. Software that services interrupts reads the normal-line status word for the low half first and then the one for the high half. Within a word it takes the lowest set bit. After handling an edge-latched line, software clears its latch by writing a 1 to it.

Top module: `irqc_top`

## Requirements
- R1: After reset these registers read zero: enable, software trigger, routing select, edge latches and both-edge. The sense and edge-polarity registers read all ones, which means all lines are level-sensitive and rising-edge. Both output lines are low.
- R2: Source n maps to bit n%32 of word n/32. The base offsets are:
  - 0x00 normal status; 0x08 fast status; 0x10 raw status
  - 0x18 routing select; 0x20 enable-set; 0x28 enable-clear
  - 0x30 trigger-set; 0x38 trigger-clear
  - 0x40 sense; 0x48 both-edge; 0x50 edge polarity
  - 0x58 edge-clear; 0x60 edge-latch status

  The high word of each register is at base+4. Addresses with bits [1:0] not zero, and offsets above 0x64, read zero and ignore writes.
- R3: A 1 written to enable-set sets that enable bit. A 1 written to enable-clear clears it. A 0 in either write leaves that bit unchanged. Reads at 0x20 return the enable state.
- R4: A 1 written to trigger-set makes that source pending by software. A 1 written to trigger-clear removes the software request. Reads at 0x30 return the trigger state.
- R5: A routing-select bit of 0 sends the source to the normal status and output. A bit of 1 sends it to the fast status and output.
- R6: Raw status is the synchronized input for a sense bit of 1, or the edge latch for a sense bit of 0, ORed with the trigger bit. A level input becomes visible in raw status no later than three clock edges after it changes.
- R7: For a sense bit of 0, a detected edge sets a latch that holds after the input returns. The edge is rising when the polarity bit is 1 and falling when it is 0. It is either edge when the both-edge bit is 1.
- R8: A 1 written to edge-clear clears the latch of an edge-sensitive source. On a level-sensitive source it has no effect. An edge detected in the same cycle as the clear write leaves the latch set.
- R9: Normal status equals raw AND enable AND NOT select. Fast status equals raw AND enable AND select. Each reads zero when nothing qualifies.
- R10: irq_o is the OR of both normal status words. fiq_o is the OR of both fast status words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 64 | Asynchronous interrupt inputs |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, zero when idle |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The hardest case to create is an edge clear that lands in the same cycle as a freshly detected edge on the same source. The input passes through two synchronizer flops and an edge history flop before the latch. The bench therefore raises the input on a falling clock edge and waits one more falling edge. It then issues the clear write so that the write is active at the exact rising edge where the edge is detected, and reads the latch status afterwards. It also covers polarity changes, the both-edge mode, and clear writes aimed at level sources.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int WORD_W = 32;

    localparam logic [3:0] RG_IRQ   = 4'd0;
    localparam logic [3:0] RG_FIQ   = 4'd1;
    localparam logic [3:0] RG_RAW   = 4'd2;
    localparam logic [3:0] RG_SEL   = 4'd3;
    localparam logic [3:0] RG_EN    = 4'd4;
    localparam logic [3:0] RG_ENC   = 4'd5;
    localparam logic [3:0] RG_TRG   = 4'd6;
    localparam logic [3:0] RG_TRC   = 4'd7;
    localparam logic [3:0] RG_SENSE = 4'd8;
    localparam logic [3:0] RG_DUAL  = 4'd9;
    localparam logic [3:0] RG_EVT   = 4'd10;
    localparam logic [3:0] RG_ECLR  = 4'd11;
    localparam logic [3:0] RG_EST   = 4'd12;

    typedef struct packed {
        logic sel;
        logic en_set;
        logic en_clr;
        logic trg_set;
        logic trg_clr;
        logic sense;
        logic dual;
        logic evt;
        logic eclr;
    } wr_strb_t;

    typedef struct packed {
        logic [WORD_W-1:0] en;
        logic [WORD_W-1:0] trg;
        logic [WORD_W-1:0] sel;
        logic [WORD_W-1:0] sense;
        logic [WORD_W-1:0] dual;
        logic [WORD_W-1:0] evt;
        logic [WORD_W-1:0] latch;
        logic [WORD_W-1:0] prev;
    } word_st_t;

    typedef struct packed {
        logic [WORD_W-1:0] irq;
        logic [WORD_W-1:0] fiq;
        logic [WORD_W-1:0] raw;
        logic [WORD_W-1:0] sel;
        logic [WORD_W-1:0] en;
        logic [WORD_W-1:0] trg;
        logic [WORD_W-1:0] sense;
        logic [WORD_W-1:0] dual;
        logic [WORD_W-1:0] evt;
        logic [WORD_W-1:0] latch;
    } word_view_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/irqc_word.sv
module irqc_word
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] lvl,
    input  wr_strb_t          wr,
    input  logic [WORD_W-1:0] wdata,
    output word_view_t        view
);
    localparam word_st_t RST_ST = '{
        en: '0, trg: '0, sel: '0, sense: '1,
        dual: '0, evt: '1, latch: '0, prev: '0
    };

    word_st_t st_d, st_q;
    logic [WORD_W-1:0] rise, fall, det, clr_m, pend, raw;

    always_comb begin
        st_d  = st_q;
        rise  = lvl & ~st_q.prev;
        fall  = ~lvl & st_q.prev;
        det   = (st_q.dual & (rise | fall))
              | (~st_q.dual & st_q.evt & rise)
              | (~st_q.dual & ~st_q.evt & fall);
        clr_m = wr.eclr ? (wdata & ~st_q.sense) : '0;

        st_d.prev = lvl;
        if (wr.sel)     st_d.sel   = wdata;
        if (wr.en_set)  st_d.en    = st_q.en | wdata;
        if (wr.en_clr)  st_d.en    = st_q.en & ~wdata;
        if (wr.trg_set) st_d.trg   = st_q.trg | wdata;
        if (wr.trg_clr) st_d.trg   = st_q.trg & ~wdata;
        if (wr.sense)   st_d.sense = wdata;
        if (wr.dual)    st_d.dual  = wdata;
        if (wr.evt)     st_d.evt   = wdata;
        // a new edge wins over a simultaneous clear
        st_d.latch = (st_q.latch & ~clr_m) | (det & ~st_q.sense);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    always_comb begin
        pend       = (st_q.sense & lvl) | (~st_q.sense & st_q.latch);
        raw        = pend | st_q.trg;
        view.raw   = raw;
        view.irq   = raw & st_q.en & ~st_q.sel;
        view.fiq   = raw & st_q.en & st_q.sel;
        view.sel   = st_q.sel;
        view.en    = st_q.en;
        view.trg   = st_q.trg;
        view.sense = st_q.sense;
        view.dual  = st_q.dual;
        view.evt   = st_q.evt;
        view.latch = st_q.latch;
    end

    p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr.en_set |=> ((st_q.en & $past(wdata)) == $past(wdata)));
    p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr.en_clr |=> ((st_q.en & $past(wdata)) == '0));
    p_trg_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr.trg_set |=> ((st_q.trg & $past(wdata)) == $past(wdata)));
    p_trg_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr.trg_clr |=> ((st_q.trg & $past(wdata)) == '0));
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr.eclr |=> ((st_q.latch & $past(st_q.latch)) == $past(st_q.latch)));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam int WORDS = NUM_SRC / WORD_W;

    logic [NUM_SRC-1:0] lvl;
    logic [3:0]         rg;
    logic               aligned, wsel, wr_hit;
    word_view_t         view [WORDS];
    word_view_t         cur;

    irqc_sync #(.W(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_in),
        .sync_out (lvl)
    );

    assign rg      = bus_addr[6:3];
    assign wsel    = bus_addr[2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_hit  = bus_sel & bus_we & aligned;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        wr_strb_t strb;
        logic     mine;
        assign mine = wr_hit & (wsel == (g == 1));
        always_comb begin
            strb.sel     = mine & (rg == RG_SEL);
            strb.en_set  = mine & (rg == RG_EN);
            strb.en_clr  = mine & (rg == RG_ENC);
            strb.trg_set = mine & (rg == RG_TRG);
            strb.trg_clr = mine & (rg == RG_TRC);
            strb.sense   = mine & (rg == RG_SENSE);
            strb.dual    = mine & (rg == RG_DUAL);
            strb.evt     = mine & (rg == RG_EVT);
            strb.eclr    = mine & (rg == RG_ECLR);
        end
        irqc_word u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (lvl[g*WORD_W +: WORD_W]),
            .wr    (strb),
            .wdata (bus_wdata),
            .view  (view[g])
        );
    end

    assign cur = view[wsel];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we && aligned) begin
            case (rg)
                RG_IRQ:   bus_rdata = cur.irq;
                RG_FIQ:   bus_rdata = cur.fiq;
                RG_RAW:   bus_rdata = cur.raw;
                RG_SEL:   bus_rdata = cur.sel;
                RG_EN:    bus_rdata = cur.en;
                RG_TRG:   bus_rdata = cur.trg;
                RG_SENSE: bus_rdata = cur.sense;
                RG_DUAL:  bus_rdata = cur.dual;
                RG_EVT:   bus_rdata = cur.evt;
                RG_EST:   bus_rdata = cur.latch;
                default:  bus_rdata = '0;
            endcase
        end
    end

    always_comb begin
        irq_o = 1'b0;
        fiq_o = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
            irq_o = irq_o | (|view[i].irq);
            fiq_o = fiq_o | (|view[i].fiq);
        end
    end

    p_out_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && fiq_o) |-> ((view[0].sel | view[1].sel) != '0));
endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;
    logic        chk_pins = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          pins;
        logic [6:0]  addr;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #(CLK_NS/2) clk = ~clk;

    irqc_top u_irqc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] e, input string r);
        item_t it;
        it.pins = 1'b0; it.addr = a; it.exp = e; it.req = r;
        @(negedge clk);
        sb.push_back(it);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pins(input logic fiq_e, input logic irq_e, input string r);
        item_t it;
        it.pins = 1'b1; it.addr = '0; it.exp = {30'd0, fiq_e, irq_e}; it.req = r;
        @(negedge clk);
        sb.push_back(it);
        chk_pins = 1'b1;
        @(negedge clk);
        chk_pins = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare against scoreboard in the low clock phase
    always @(negedge clk) begin
        #1;
        if ((bus_sel && !bus_we) || chk_pins) begin
            item_t it;
            logic [31:0] got;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty got %h exp none", bus_rdata);
            end else begin
                it = sb.pop_front();
                got = it.pins ? {30'd0, fiq_o, irq_o} : bus_rdata;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr %h got %h exp %h", it.req, it.addr, got, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(7'h40, 32'hFFFF_FFFF, "R1 sense lo");
        rd(7'h44, 32'hFFFF_FFFF, "R1 sense hi");
        rd(7'h20, 32'h0, "R1 enable");
        rd(7'h50, 32'hFFFF_FFFF, "R1 polarity");
        rd(7'h48, 32'h0, "R1 dual");
        rd(7'h60, 32'h0, "R1 latch");
        pins(1'b0, 1'b0, "R1 pins");

        // R6 level source visible in raw, R9 not enabled
        @(negedge clk); src_in[3] = 1'b1;
        idle(3);
        rd(7'h10, 32'h8, "R6 raw level");
        rd(7'h00, 32'h0, "R9 masked");
        pins(1'b0, 1'b0, "R10 masked");

        // R3 enable, R9 status, R10 irq line
        wr(7'h20, 32'h8);
        rd(7'h20, 32'h8, "R3 enable set");
        rd(7'h00, 32'h8, "R9 irq status");
        pins(1'b0, 1'b1, "R10 irq line");

        // R5 routing to fast output
        wr(7'h18, 32'h8);
        rd(7'h00, 32'h0, "R5 irq status");
        rd(7'h08, 32'h8, "R5 fiq status");
        pins(1'b1, 1'b0, "R5 fiq line");
        wr(7'h28, 32'h8);
        rd(7'h20, 32'h0, "R3 enable clear");
        pins(1'b0, 1'b0, "R3 masked");
        wr(7'h18, 32'h0);

        // R3 zero bits leave enable unchanged
        wr(7'h20, 32'h3);
        wr(7'h20, 32'h4);
        rd(7'h20, 32'h7, "R3 accumulate");
        wr(7'h28, 32'h1);
        rd(7'h20, 32'h6, "R3 partial clear");
        wr(7'h28, 32'hFFFF_FFFF);
        rd(7'h20, 32'h0, "R3 clear all");

        // R2 high word mapping
        @(negedge clk); src_in[40] = 1'b1;
        idle(3);
        rd(7'h14, 32'h100, "R2 raw hi");
        rd(7'h10, 32'h8, "R2 raw lo");
        wr(7'h24, 32'h100);
        rd(7'h04, 32'h100, "R2 irq hi");
        rd(7'h00, 32'h0, "R2 irq lo");
        pins(1'b0, 1'b1, "R10 hi word");
        rd(7'h25, 32'h0, "R2 misaligned");
        @(negedge clk); src_in[40] = 1'b0;
        idle(3);
        pins(1'b0, 1'b0, "R10 hi drop");
        wr(7'h2C, 32'hFFFF_FFFF);

        // R4 software trigger
        wr(7'h30, 32'h1);
        rd(7'h10, 32'h9, "R4 raw trig");
        rd(7'h30, 32'h1, "R4 trig read");
        wr(7'h20, 32'h1);
        pins(1'b0, 1'b1, "R4 trig line");
        wr(7'h38, 32'h1);
        rd(7'h10, 32'h8, "R4 trig clear");
        pins(1'b0, 1'b0, "R4 line drop");
        wr(7'h28, 32'h1);

        // R7 rising edge latch on source 5
        wr(7'h40, 32'hFFFF_FFDF);
        @(negedge clk); src_in[5] = 1'b1;
        idle(3);
        rd(7'h60, 32'h20, "R7 rising");
        rd(7'h10, 32'h28, "R6 raw edge");
        @(negedge clk); src_in[5] = 1'b0;
        idle(3);
        rd(7'h60, 32'h20, "R7 hold");
        wr(7'h58, 32'h20);
        rd(7'h60, 32'h0, "R8 clear");

        // R7 falling polarity
        wr(7'h50, 32'hFFFF_FFDF);
        @(negedge clk); src_in[5] = 1'b1;
        idle(3);
        rd(7'h60, 32'h0, "R7 rise ignored");
        @(negedge clk); src_in[5] = 1'b0;
        idle(3);
        rd(7'h60, 32'h20, "R7 falling");
        wr(7'h58, 32'h20);
        rd(7'h60, 32'h0, "R8 clear fall");

        // R7 both edges
        wr(7'h48, 32'h20);
        @(negedge clk); src_in[5] = 1'b1;
        idle(3);
        rd(7'h60, 32'h20, "R7 dual rise");
        wr(7'h58, 32'h20);
        rd(7'h60, 32'h0, "R8 clear dual");
        @(negedge clk); src_in[5] = 1'b0;
        idle(3);
        rd(7'h60, 32'h20, "R7 dual fall");
        wr(7'h58, 32'h20);

        // R8 edge-clear on a level source has no effect
        wr(7'h58, 32'h8);
        rd(7'h10, 32'h8, "R8 level untouched");

        // R8 new edge coincides with clear write
        wr(7'h48, 32'h0);
        wr(7'h50, 32'hFFFF_FFFF);
        rd(7'h60, 32'h0, "R8 precondition");
        @(negedge clk); src_in[5] = 1'b1;
        @(negedge clk);
        wr(7'h58, 32'h20);
        idle(2);
        rd(7'h60, 32'h20, "R8 edge wins");
        wr(7'h58, 32'h20);
        rd(7'h60, 32'h0, "R8 final clear");

        idle(3);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover got %0d exp 0", sb.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule